// File: doc/BRIEF.md
# Configurable Serial Slave Address Filter

This block sits behind the byte shifter of a serial control port and decides, at the start of every transaction, whether the transaction is meant for this device. The first byte of each transaction carries a 7-bit device address and a read/write flag. The filter compares that address with a stored one when checking is enabled, and raises either a held `match` level or a single-cycle `reject` pulse. Out of reset, checking is off and every transaction is accepted.

The host enables checking and sets the address by sending a fixed four-word sequence of 24-bit configuration words. The first pair is a mask step that clears the address/enable field. The second pair is a set step that writes the new field. The update is committed atomically when the fourth word arrives. Configuration is accepted only inside a window that opens at reset or soft reset and closes on a kickstart command. After that, configuration words leave the stored settings untouched.

Top module: `slv_addr_gate`

## Requirements
- R1: After reset, checking is disabled, the stored address is 0, `cfg_locked` is 0, and `match`, `reject` and `rw_bit` are all 0.
- R2: A first byte carries the device address in bits 7:1 and the read/write flag in bit 0. On acceptance, `rw_bit` takes bit 0 and is held together with `match`. On rejection, `rw_bit` is 0.
- R3: While checking is disabled, every first byte is accepted, whatever its address. `match` rises in the cycle after the byte, and `reject` stays low.
- R4: The words 0x800252, 0x00FFFF, 0x800152 and then a value word whose bits 15:0 are zero, each with `cfg_valid` high, commit on the edge of the value word. The value word's bits 23:17 become the stored address and its bit 16 becomes the enable (1 = checking on). Earlier settings are fully replaced.
- R5: While checking is enabled, a first byte whose address equals the stored one sets `match`. Any other address gives a `reject` pulse exactly one cycle long, with `match` low. `match` and `reject` are never high together.
- R6: An unexpected word inside the sequence returns the parser to idle without changing the stored settings. A 0x800252 word always begins a new sequence. A value word with non-zero bits 15:0 aborts the sequence.
- R7: A kickstart pulse sets `cfg_locked` in the next cycle and discards any partial sequence. While locked, configuration words never change the stored settings.
- R8: A soft reset pulse restores the R1 state in the next cycle, reopens the configuration window and discards a partial sequence.
- R9: Only the first byte after `txn_start` is evaluated. A byte in the same cycle as `txn_start` counts as that first byte. Later bytes, and bytes with no preceding `txn_start`, leave `match`, `reject` and `rw_bit` unchanged. `txn_start` clears `match` and `rw_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous restore of defaults and reopening of the window |
| kickstart | input | 1 | Closes the configuration window |
| cfg_valid | input | 1 | Qualifies `cfg_word` |
| cfg_word | input | 24 | Host configuration word |
| txn_start | input | 1 | Marks the start of a serial transaction |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Received byte: address in 7:1, read/write flag in 0 |
| match | output | 1 | Transaction accepted, held until next `txn_start` |
| reject | output | 1 | One-cycle pulse on an address mismatch |
| rw_bit | output | 1 | Read/write flag of the accepted transaction |
| cfg_locked | output | 1 | Configuration window closed |

## Verification
`match`, `reject` and `rw_bit` are registered, so each is due one cycle after the clock edge that takes the first byte. The bench drives on the falling edge and samples on the next falling edge. It then samples again one cycle later to confirm that `reject` has dropped and `match` is still held.

A committed configuration is first visible on a transaction driven after the edge of the value word. `cfg_locked` and the soft-reset defaults are checked one cycle after their strobe. Every check compares against a reference model of the stored settings and the parser stage, built in the bench from the requirements.

// File: rtl/slv_addr_gate_pkg.sv
package slv_addr_gate_pkg;

   localparam int unsigned SAG_CFG_W     = 24;
   localparam int unsigned SAG_ADDR_W    = 7;
   localparam int unsigned SAG_FIELD_LSB = 16;

   // parser position inside the four-word configuration sequence
   typedef enum logic [1:0] {
      SEQ_IDLE     = 2'd0,
      SEQ_GOT_AND  = 2'd1,
      SEQ_GOT_MASK = 2'd2,
      SEQ_GOT_OR   = 2'd3
   } sag_seq_e;

endpackage

// File: rtl/sag_seq_parser.sv
module sag_seq_parser
   import slv_addr_gate_pkg::*;
#(
   parameter int unsigned CFG_W     = SAG_CFG_W,
   parameter int unsigned FIELD_LSB = SAG_FIELD_LSB,
   parameter int unsigned FIELD_W   = SAG_ADDR_W + 1,
   parameter logic [CFG_W-1:0] HDR_AND   = 24'h800252,
   parameter logic [CFG_W-1:0] MASK_WORD = 24'h00FFFF,
   parameter logic [CFG_W-1:0] HDR_OR    = 24'h800152
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_reset,
   input  logic               kickstart,
   input  logic               locked,
   input  logic               cfg_valid,
   input  logic [CFG_W-1:0]   cfg_word,
   output logic               commit,
   output logic [FIELD_W-1:0] commit_mask,
   output logic [FIELD_W-1:0] commit_val
);

   sag_seq_e           st_q, st_d;
   logic [FIELD_W-1:0] mask_q;
   logic               is_and, is_mask, is_or, low_zero;
   sag_seq_e           restart;

   assign is_and  = (cfg_word == HDR_AND);
   assign is_mask = (cfg_word == MASK_WORD);
   assign is_or   = (cfg_word == HDR_OR);
   assign restart = is_and ? SEQ_GOT_AND : SEQ_IDLE;

   generate
      if (FIELD_LSB > 0) begin : g_low
         assign low_zero = (cfg_word[FIELD_LSB-1:0] == '0);
      end else begin : g_nolow
         assign low_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      commit = 1'b0;
      if (soft_reset || kickstart || locked) begin
         st_d = SEQ_IDLE;
      end else if (cfg_valid) begin
         unique case (st_q)
            SEQ_IDLE:     st_d = restart;
            SEQ_GOT_AND:  st_d = is_mask ? SEQ_GOT_MASK : restart;
            SEQ_GOT_MASK: st_d = is_or ? SEQ_GOT_OR : restart;
            SEQ_GOT_OR: begin
               if (low_zero) begin
                  commit = 1'b1;
                  st_d   = SEQ_IDLE;
               end else begin
                  st_d = restart;
               end
            end
            default:      st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         mask_q <= '1;
      end else begin
         st_q <= st_d;
         if (st_q == SEQ_GOT_AND && st_d == SEQ_GOT_MASK)
            mask_q <= cfg_word[FIELD_LSB +: FIELD_W];
      end
   end

   assign commit_mask = mask_q;
   assign commit_val  = cfg_word[FIELD_LSB +: FIELD_W];

endmodule

// File: rtl/sag_chk_reg.sv
module sag_chk_reg #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned FIELD_W = ADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_reset,
   input  logic               kickstart,
   input  logic               commit,
   input  logic [FIELD_W-1:0] commit_mask,
   input  logic [FIELD_W-1:0] commit_val,
   output logic [FIELD_W-1:0] field,
   output logic               chk_en,
   output logic [ADDR_W-1:0]  dev_addr,
   output logic               locked
);

   logic [FIELD_W-1:0] field_q;
   logic               locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q  <= '0;
         locked_q <= 1'b0;
      end else if (soft_reset) begin
         field_q  <= '0;
         locked_q <= 1'b0;
      end else begin
         if (kickstart)
            locked_q <= 1'b1;
         if (commit && !locked_q)
            field_q <= (field_q & commit_mask) | commit_val;
      end
   end

   assign field    = field_q;
   assign chk_en   = field_q[0];
   assign dev_addr = field_q[FIELD_W-1:1];
   assign locked   = locked_q;

endmodule

// File: rtl/sag_addr_match.sv
module sag_addr_match #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned BYTE_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_reset,
   input  logic              chk_en,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic              txn_start,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              match,
   output logic              reject,
   output logic              rw_bit
);

   logic [ADDR_W-1:0] bit_eq;
   logic              addr_eq, take, accept;
   logic              armed_q, match_q, reject_q, rw_q;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
      assign bit_eq[i] = ~(byte_data[i+1] ^ dev_addr[i]);
   end

   assign addr_eq = &bit_eq;
   assign take    = byte_valid && (armed_q || txn_start);
   assign accept  = !chk_en || addr_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         match_q  <= 1'b0;
         reject_q <= 1'b0;
         rw_q     <= 1'b0;
      end else if (soft_reset) begin
         armed_q  <= 1'b0;
         match_q  <= 1'b0;
         reject_q <= 1'b0;
         rw_q     <= 1'b0;
      end else begin
         reject_q <= 1'b0;
         if (take) begin
            armed_q  <= 1'b0;
            match_q  <= accept;
            reject_q <= !accept;
            rw_q     <= accept & byte_data[0];
         end else if (txn_start) begin
            armed_q <= 1'b1;
            match_q <= 1'b0;
            rw_q    <= 1'b0;
         end
      end
   end

   assign match  = match_q;
   assign reject = reject_q;
   assign rw_bit = rw_q;

endmodule

// File: rtl/slv_addr_gate.sv
module slv_addr_gate
   import slv_addr_gate_pkg::*;
#(
   parameter int unsigned CFG_W     = SAG_CFG_W,
   parameter int unsigned ADDR_W    = SAG_ADDR_W,
   parameter int unsigned FIELD_LSB = SAG_FIELD_LSB,
   parameter logic [CFG_W-1:0] HDR_AND   = 24'h800252,
   parameter logic [CFG_W-1:0] MASK_WORD = 24'h00FFFF,
   parameter logic [CFG_W-1:0] HDR_OR    = 24'h800152
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_reset,
   input  logic              kickstart,
   input  logic              cfg_valid,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              txn_start,
   input  logic              byte_valid,
   input  logic [ADDR_W:0]   byte_data,
   output logic              match,
   output logic              reject,
   output logic              rw_bit,
   output logic              cfg_locked
);

   localparam int unsigned FIELD_W = ADDR_W + 1;
   localparam int unsigned BYTE_W  = ADDR_W + 1;

   generate
      if (FIELD_LSB + FIELD_W != CFG_W) begin : g_bad_field
         $error("address field must end at the top bit of the config word");
      end
      if (FIELD_LSB == 0) begin : g_bad_lsb
         $error("value word needs a non-empty zero-checked low part");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be at least one bit");
      end
   endgenerate

   logic               commit;
   logic [FIELD_W-1:0] commit_mask, commit_val, chk_field;
   logic               chk_en, locked;
   logic [ADDR_W-1:0]  dev_addr;

   sag_seq_parser #(
      .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
      .HDR_AND(HDR_AND), .MASK_WORD(MASK_WORD), .HDR_OR(HDR_OR)
   ) u_parser (
      .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .kickstart(kickstart),
      .locked(locked), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
      .commit(commit), .commit_mask(commit_mask), .commit_val(commit_val)
   );

   sag_chk_reg #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .kickstart(kickstart),
      .commit(commit), .commit_mask(commit_mask), .commit_val(commit_val),
      .field(chk_field), .chk_en(chk_en), .dev_addr(dev_addr), .locked(locked)
   );

   sag_addr_match #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_match (
      .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .chk_en(chk_en),
      .dev_addr(dev_addr), .txn_start(txn_start), .byte_valid(byte_valid),
      .byte_data(byte_data), .match(match), .reject(reject), .rw_bit(rw_bit)
   );

   assign cfg_locked = locked;

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
   parameter int unsigned CFG_W     = 24,
   parameter int unsigned FIELD_LSB = 16,
   parameter int unsigned FIELD_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_reset,
   input logic               kickstart,
   input logic               cfg_valid,
   input logic [CFG_W-1:0]   cfg_word,
   input logic               byte_valid,
   input logic [FIELD_W-1:0] chk_field,
   input logic               match,
   input logic               reject,
   input logic               rw_bit,
   input logic               cfg_locked
);

   p_rw_with_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rw_bit |-> match);

   p_accept_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match) |-> $past(byte_valid));

   p_commit_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(chk_field) && !$past(soft_reset)) |->
         ($past(cfg_valid) && $past(cfg_word[FIELD_LSB-1:0]) == '0 && !$past(cfg_locked)));

   p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(match && reject));

   p_reject_only_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> $past(chk_field[0]));

   p_no_reject_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(chk_field[0]) && $past(byte_valid)) |-> !reject);

   p_kick_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kickstart && !soft_reset) |=> cfg_locked);

   p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_locked) && !$past(soft_reset)) |-> $stable(chk_field));

   p_soft_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |=> (!cfg_locked && chk_field == '0 && !match && !reject && !rw_bit));

endmodule

bind slv_addr_gate sag_checker #(
   .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
) u_sag_chk (
   .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .kickstart(kickstart),
   .cfg_valid(cfg_valid), .cfg_word(cfg_word), .byte_valid(byte_valid),
   .chk_field(chk_field), .match(match), .reject(reject), .rw_bit(rw_bit),
   .cfg_locked(cfg_locked)
);

// File: tb/slv_addr_gate_tb_top.sv
`timescale 1ns/1ps
module slv_addr_gate_tb_top;

   localparam logic [23:0] W_AND  = 24'h800252;
   localparam logic [23:0] W_MASK = 24'h00FFFF;
   localparam logic [23:0] W_OR   = 24'h800152;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_reset = 1'b0, kickstart = 1'b0, cfg_valid = 1'b0;
   logic [23:0] cfg_word = '0;
   logic        txn_start = 1'b0, byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        match, reject, rw_bit, cfg_locked;

   int n_chk = 0;
   int n_err = 0;

   // reference model
   bit       m_en = 0;
   bit [6:0] m_addr = '0;
   bit       m_locked = 0;
   int       m_stage = 0;
   bit       m_match = 0;
   bit       m_rw = 0;

   always #4 clk = ~clk;

   slv_addr_gate dut_i (
      .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .kickstart(kickstart),
      .cfg_valid(cfg_valid), .cfg_word(cfg_word), .txn_start(txn_start),
      .byte_valid(byte_valid), .byte_data(byte_data), .match(match),
      .reject(reject), .rw_bit(rw_bit), .cfg_locked(cfg_locked)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_accept(bit en, bit [6:0] a, bit [7:0] b);
      return !en || (b[7:1] == a);
   endfunction

   function automatic int step_after(int st, logic [23:0] w);
      int rs = (w == W_AND) ? 1 : 0;
      case (st)
         0: return rs;
         1: return (w == W_MASK) ? 2 : rs;
         2: return (w == W_OR) ? 3 : rs;
         default: return (w[15:0] == 16'h0) ? 0 : rs;
      endcase
   endfunction

   task automatic send_cfg(logic [23:0] w);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_word = w;
      @(negedge clk);
      cfg_valid = 1'b0;
      if (!m_locked) begin
         if (m_stage == 3 && w[15:0] == 16'h0) begin
            m_addr = w[23:17]; m_en = w[16];
         end
         m_stage = step_after(m_stage, w);
      end
   endtask

   task automatic full_seq(bit [6:0] a, bit en);
      send_cfg(W_AND); send_cfg(W_MASK); send_cfg(W_OR);
      send_cfg({a, en, 16'h0});
   endtask

   // transaction: start and byte together (split=0) or start then byte
   task automatic txn(bit [7:0] b, bit split, bit trailer, string req);
      bit acc;
      @(negedge clk);
      txn_start = 1'b1; byte_valid = !split; byte_data = b;
      if (split) begin
         @(negedge clk);
         check({req, " start clears match"}, match, 0);
         txn_start = 1'b0; byte_valid = 1'b1;
      end
      @(negedge clk);
      txn_start = 1'b0; byte_valid = 1'b0;
      acc = exp_accept(m_en, m_addr, b);
      m_match = acc; m_rw = acc & b[0];
      check({req, " match"}, match, acc);
      check({req, " reject"}, reject, !acc);
      check({req, " rw_bit R2"}, rw_bit, m_rw);
      if (trailer) begin
         byte_valid = 1'b1; byte_data = ~b;
      end
      @(negedge clk);
      byte_valid = 1'b0;
      check("R5 reject one cycle", reject, 0);
      check({req, " R9 hold match"}, match, m_match);
      check("R9 hold rw_bit", rw_bit, m_rw);
   endtask

   task automatic kick();
      @(negedge clk); kickstart = 1'b1;
      @(negedge clk); kickstart = 1'b0;
      m_locked = 1; m_stage = 0;
      check("R7 locked after kickstart", cfg_locked, 1);
   endtask

   task automatic sreset();
      @(negedge clk); soft_reset = 1'b1;
      @(negedge clk); soft_reset = 1'b0;
      m_locked = 0; m_stage = 0; m_en = 0; m_addr = '0; m_match = 0; m_rw = 0;
      check("R8 unlocked", cfg_locked, 0);
      check("R8 match cleared", match, 0);
      check("R8 rw cleared", rw_bit, 0);
   endtask

   // probe the stored settings through the transaction path
   task automatic probe(string req);
      txn({m_addr, 1'b1}, 0, 0, req);
      txn({m_addr ^ 7'h55, 1'b0}, 0, 0, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int unused_seed;
      unused_seed = $urandom(32'd7341);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 match", match, 0);
      check("R1 reject", reject, 0);
      check("R1 rw_bit", rw_bit, 0);
      check("R1 cfg_locked", cfg_locked, 0);

      // R3: disabled, any address accepted
      txn(8'hA5, 0, 0, "R3");
      txn(8'h00, 1, 0, "R3");
      txn(8'hFF, 0, 1, "R3");

      // R4/R5: enable with address 0x2A
      full_seq(7'h2A, 1'b1);
      txn({7'h2A, 1'b1}, 0, 0, "R4");
      txn({7'h2B, 1'b1}, 0, 0, "R5");
      txn({7'h2A, 1'b0}, 1, 1, "R9");
      txn({7'h11, 1'b1}, 0, 1, "R9 after reject");
      // byte without start is ignored
      @(negedge clk); byte_valid = 1'b1; byte_data = {7'h2A, 1'b1};
      @(negedge clk); byte_valid = 1'b0;
      check("R9 stray byte match", match, 0);
      check("R9 stray byte reject", reject, 0);

      // R6: broken sequence leaves settings
      send_cfg(W_AND); send_cfg(W_MASK); send_cfg(24'h123456);
      send_cfg({7'h33, 1'b1, 16'h0});
      probe("R6 broken");
      send_cfg(W_AND); send_cfg(W_MASK); send_cfg(W_OR);
      send_cfg({7'h33, 1'b1, 16'h0001});
      probe("R6 nonzero low");
      send_cfg(W_AND); send_cfg(W_AND); send_cfg(W_MASK); send_cfg(W_OR);
      send_cfg({7'h33, 1'b1, 16'h0});
      probe("R6 restart");
      check("R6 restart addr", m_addr, 7'h33);

      // R4: disabling again
      full_seq(7'h7F, 1'b0);
      txn(8'h02, 0, 0, "R4 disable");

      // R7: partial then kick, then sequences ignored
      full_seq(7'h10, 1'b1);
      send_cfg(W_AND); send_cfg(W_MASK);
      kick();
      send_cfg(W_OR); send_cfg({7'h05, 1'b1, 16'h0});
      full_seq(7'h05, 1'b1);
      probe("R7 locked");

      // R8: soft reset restores defaults
      sreset();
      txn(8'h3C, 0, 0, "R8 disabled");
      send_cfg(W_AND); send_cfg(W_MASK); send_cfg(W_OR);
      sreset();
      send_cfg({7'h22, 1'b1, 16'h0});
      probe("R8 partial dropped");

      // constrained random mix
      for (int it = 0; it < 500; it++) begin
         int r = $urandom_range(0, 99);
         if (r < 30) begin
            bit [7:0] b = $urandom_range(0, 255);
            if ($urandom_range(0, 1) == 1) b[7:1] = m_addr;
            txn(b, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R5 rnd");
         end else if (r < 48) begin
            full_seq(7'($urandom_range(0, 127)), $urandom_range(0, 1) == 1);
         end else if (r < 64) begin
            int k = $urandom_range(0, 4);
            logic [23:0] w;
            case (k)
               0: w = W_AND;
               1: w = W_MASK;
               2: w = W_OR;
               3: w = {7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)), 16'h0};
               default: w = 24'($urandom);
            endcase
            send_cfg(w);
         end else if (r < 67) begin
            kick();
         end else if (r < 71) begin
            sreset();
         end else begin
            probe("R4 rnd");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule